// File: doc/BRIEF.md
# Serial Segment-Display Command and Data Receiver

This block is the host-facing front end of a segment LCD controller with four commons. A host shifts 8-bit frames into it over a chip-select-gated serial clock and data line, most significant bit first. A command/data select line, sampled only on the edge that completes a frame, marks each frame as a command or as display data. Command frames load the address counter, choose the display mode or clear the controller state. Data frames store two 4-bit words in a 32-word display memory.

The serial inputs are asynchronous to the system clock. They pass through a shared two-stage synchroniser, and a rising serial clock is detected in the system clock domain. The waveform generator that drives the commons and segments reads the display memory through a combinational read port. It also reads the current display mode. Bit n of each memory word belongs to common n, and word k belongs to segment k.

Top module: `lcd_serial_if`

## Requirements
- R1: While rst_ni is low, and after it is released, disp_mode_o reads 0 (all segments off), the address counter holds 0 and every memory word reads 0.
- R2: Serial data is shifted in on rising sck_i edges, one bit per edge, MSB first, and only while cs_ni is low. Rising edges while cs_ni is high have no effect.
- R3: A frame that cs_ni ends before its eighth edge is discarded. A falling cs_ni starts a new frame at bit 7.
- R4: When cd_i is low on the eighth edge, the frame is display data. Bits [7:4] are written to the current address, bits [3:0] are written to address+1, and the counter advances by 2.
- R5: A command whose opcode in bits [7:5] is 000 loads bits [4:0] into the address counter.
- R6: Opcode 001 sets disp_mode_o to 1 (all on), 010 sets it to 0 (all off) and 011 sets it to 2 (show memory). None of them changes the memory. disp_mode_o changes only on these commands, on opcode 110 and on reset.
- R7: Opcode 100 writes bits [3:0] to the current address and advances the counter by 1. Bit 4 is ignored.
- R8: Opcode 110 clears the address counter and sets disp_mode_o to 0, leaving the memory unchanged.
- R9: The address counter wraps from 31 to 0. A data frame at address 31 writes its low nibble to address 0.
- R10: Opcodes 101 and 111 change neither the counter, the mode nor the memory.
- R11: cd_i is sampled only on the eighth edge of a frame. Its level on earlier edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial shift clock, asynchronous |
| sd_i | input | 1 | Serial data, MSB first |
| cd_i | input | 1 | Command (1) or display data (0), taken on the eighth edge |
| rd_addr_i | input | 5 | Display memory read address |
| rd_data_o | output | 4 | Display memory word at rd_addr_i |
| disp_mode_o | output | 2 | 0 all off, 1 all on, 2 show memory |

## Verification
A display-data frame fires both memory write ports in one clock cycle, and the second port's address is the incremented counter. The two writes therefore straddle the wrap boundary when the frame lands at address 31. The bench sweeps the start address over all 32 values and sends a distinct byte for each. After every frame it reads back both target words, and it compares the whole memory against an arithmetic model. The boundary case passes only if address 31 receives the high nibble and address 0 receives the low nibble in the same cycle, with no other word disturbed.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;
  localparam int ADDR_W = 5;
  localparam int NIB_W  = 4;
  localparam int OP_W   = 3;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ALL_ON = 2'd1,
    MODE_RAM    = 2'd2
  } disp_mode_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADDR = 3'b000,
    OP_ON   = 3'b001,
    OP_OFF  = 3'b010,
    OP_SHOW = 3'b011,
    OP_NIB  = 3'b100,
    OP_CLR  = 3'b110
  } opcode_e;
endpackage

// File: rtl/lcd_sync.sv
module lcd_sync #(
  parameter int             WIDTH   = 4,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_frame_rx.sv
module lcd_frame_rx #(
  parameter int FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_s_i,
  input  logic               sck_s_i,
  input  logic               sd_s_i,
  input  logic               cd_s_i,
  output logic               frame_vld_o,
  output logic               frame_cmd_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int              CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic               sck_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] shift_q;
  logic               sck_rise;
  logic               take;

  assign sck_rise = sck_s_i & ~sck_q;
  assign take     = sck_rise & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s_i;

  // idle CS holds the bit counter at 0, so a partial frame is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (cs_n_s_i) begin
      cnt_q   <= '0;
    end else if (sck_rise) begin
      shift_q <= {shift_q[FRAME_W-3:0], sd_s_i};
      cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_vld_o <= 1'b0;
      frame_cmd_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= take && (cnt_q == LAST);
      if (take && (cnt_q == LAST)) begin
        frame_cmd_o <= cd_s_i;
        frame_o     <= {shift_q, sd_s_i};
      end
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> cnt_q == '0); // R3
  AST_FRAME_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o); // R2
endmodule

// File: rtl/lcd_cmd_dec.sv
module lcd_cmd_dec
  import lcd_if_pkg::*;
#(
  parameter int ADDR_W = lcd_if_pkg::ADDR_W,
  parameter int NIB_W  = lcd_if_pkg::NIB_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic               frame_cmd_i,
  input  logic [2*NIB_W-1:0] frame_i,
  output disp_mode_e         mode_o,
  output logic               wr0_en_o,
  output logic [ADDR_W-1:0]  wr0_addr_o,
  output logic [NIB_W-1:0]   wr0_data_o,
  output logic               wr1_en_o,
  output logic [ADDR_W-1:0]  wr1_addr_o,
  output logic [NIB_W-1:0]   wr1_data_o
);
  localparam int FRAME_W = 2 * NIB_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  disp_mode_e        mode_q, mode_d;
  logic [OP_W-1:0]   op;

  assign op = frame_i[FRAME_W-1 -: OP_W];

  always_comb begin
    addr_d     = addr_q;
    mode_d     = mode_q;
    wr0_en_o   = 1'b0;
    wr1_en_o   = 1'b0;
    wr0_addr_o = addr_q;
    wr1_addr_o = addr_q + ADDR_W'(1);
    wr0_data_o = frame_i[FRAME_W-1 -: NIB_W];
    wr1_data_o = frame_i[NIB_W-1:0];
    if (frame_vld_i) begin
      if (!frame_cmd_i) begin
        wr0_en_o = 1'b1;
        wr1_en_o = 1'b1;
        addr_d   = addr_q + ADDR_W'(2);
      end else begin
        case (op)
          OP_ADDR: addr_d = frame_i[ADDR_W-1:0];
          OP_ON:   mode_d = MODE_ALL_ON;
          OP_OFF:  mode_d = MODE_OFF;
          OP_SHOW: mode_d = MODE_RAM;
          OP_NIB: begin
            wr0_en_o   = 1'b1;
            wr0_data_o = frame_i[NIB_W-1:0];
            addr_d     = addr_q + ADDR_W'(1);
          end
          OP_CLR: begin
            addr_d = '0;
            mode_d = MODE_OFF;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_q <= '0;
      mode_q <= MODE_OFF;
    end else begin
      addr_q <= addr_d;
      mode_q <= mode_d;
    end

  assign mode_o = mode_q;

  AST_DATA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && !frame_cmd_i |=> addr_q == $past(addr_q) + ADDR_W'(2)); // R4
  AST_ADDR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && frame_cmd_i && op == OP_ADDR |=> addr_q == $past(frame_i[ADDR_W-1:0])); // R5
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_vld_i && frame_cmd_i) |=> $stable(mode_q)); // R6
  AST_NIB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && frame_cmd_i && op == OP_NIB |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R7
  AST_CLR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && frame_cmd_i && op == OP_CLR |=> addr_q == '0 && mode_q == MODE_OFF); // R8
  AST_UNUSED_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i && frame_cmd_i && (op == 3'b101 || op == 3'b111)
    |=> $stable(addr_q) && $stable(mode_q)); // R10
endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
  parameter int ADDR_W = lcd_if_pkg::ADDR_W,
  parameter int NIB_W  = lcd_if_pkg::NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr0_en_i,
  input  logic [ADDR_W-1:0] wr0_addr_i,
  input  logic [NIB_W-1:0]  wr0_data_i,
  input  logic              wr1_en_i,
  input  logic [ADDR_W-1:0] wr1_addr_i,
  input  logic [NIB_W-1:0]  wr1_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [NIB_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (wr0_en_i) mem_q[wr0_addr_i] <= wr0_data_i;
      if (wr1_en_i) mem_q[wr1_addr_i] <= wr1_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_PORT_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0_en_i && wr1_en_i |-> wr0_addr_i != wr1_addr_i); // R9
endmodule

// File: rtl/lcd_serial_if.sv
module lcd_serial_if
  import lcd_if_pkg::*;
#(
  parameter int ADDR_W      = lcd_if_pkg::ADDR_W,
  parameter int NIB_W       = lcd_if_pkg::NIB_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sd_i,
  input  logic              cd_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o,
  output logic [1:0]        disp_mode_o
);
  localparam int FRAME_W = 2 * NIB_W;

  logic [3:0]         sync_q;
  logic               frame_vld, frame_cmd;
  logic [FRAME_W-1:0] frame;
  disp_mode_e         mode;
  logic               wr0_en, wr1_en;
  logic [ADDR_W-1:0]  wr0_addr, wr1_addr;
  logic [NIB_W-1:0]   wr0_data, wr1_data;

  // all serial pins share one synchroniser so their relative timing is kept
  lcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, sck_i, sd_i, cd_i}),
    .q_o    (sync_q)
  );

  lcd_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_s_i    (sync_q[3]),
    .sck_s_i     (sync_q[2]),
    .sd_s_i      (sync_q[1]),
    .cd_s_i      (sync_q[0]),
    .frame_vld_o (frame_vld),
    .frame_cmd_o (frame_cmd),
    .frame_o     (frame)
  );

  lcd_cmd_dec #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_cmd_i (frame_cmd),
    .frame_i     (frame),
    .mode_o      (mode),
    .wr0_en_o    (wr0_en),
    .wr0_addr_o  (wr0_addr),
    .wr0_data_o  (wr0_data),
    .wr1_en_o    (wr1_en),
    .wr1_addr_o  (wr1_addr),
    .wr1_data_o  (wr1_data)
  );

  lcd_disp_ram #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ram (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr0_en_i   (wr0_en),
    .wr0_addr_i (wr0_addr),
    .wr0_data_i (wr0_data),
    .wr1_en_i   (wr1_en),
    .wr1_addr_i (wr1_addr),
    .wr1_data_i (wr1_data),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  assign disp_mode_o = mode;

  AST_RESET_OFF: assert property (@(posedge clk_i)
    !rst_ni |=> disp_mode_o == 2'd0); // R1
endmodule

// File: tb/lcd_serial_if_tb.sv
module lcd_serial_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, sd = 1'b0, cd = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic [1:0] disp_mode;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  logic [3:0] mem_m [32];
  logic [4:0] addr_m;
  logic [1:0] mode_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_serial_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sd_i(sd), .cd_i(cd),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .disp_mode_o(disp_mode)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mem_m[i] = '0;
    addr_m = '0;
    mode_m = 2'd0;
  endtask

  task automatic model_frame(logic [7:0] b, logic c);
    if (!c) begin
      mem_m[addr_m] = b[7:4];
      mem_m[addr_m + 5'd1] = b[3:0];
      addr_m = addr_m + 5'd2;
    end else begin
      case (b[7:5])
        3'b000: addr_m = b[4:0];
        3'b001: mode_m = 2'd1;
        3'b010: mode_m = 2'd0;
        3'b011: mode_m = 2'd2;
        3'b100: begin mem_m[addr_m] = b[3:0]; addr_m = addr_m + 5'd1; end
        3'b110: begin addr_m = '0; mode_m = 2'd0; end
        default: ;
      endcase
    end
  endtask

  // cd holds the inverse level on bits 7..1 and the real level only on the 8th edge (R11)
  task automatic send(logic [7:0] b, logic c, int nbits = 8);
    cs_n = 1'b0;
    clks(HALF_SCK);
    for (int i = 7; i > 7 - nbits; i--) begin
      sd = b[i];
      cd = (i == 0) ? c : ~c;
      clks(HALF_SCK);
      sck = 1'b1;
      clks(HALF_SCK);
      sck = 1'b0;
    end
    clks(HALF_SCK);
    cs_n = 1'b1;
    clks(6);
    if (nbits == 8) model_frame(b, c);
  endtask

  task automatic read_word(logic [4:0] a, string req);
    rd_addr = a;
    clks(1);
    check(req, int'(rd_data), int'(mem_m[a]));
  endtask

  task automatic check_all(string req);
    for (int a = 0; a < 32; a++) read_word(5'(a), req);
    check(req, int'(disp_mode), int'(mode_m));
  endtask

  initial begin
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    clks(3);
    check("R1 mode in reset", int'(disp_mode), 0);
    rst_n = 1'b1;
    clks(3);
    check_all("R1 after reset");

    // R4 R9: data frame at every start address, including 31 -> 0 wrap
    for (int a = 0; a < 32; a++) begin
      send(8'(a), 1'b1);              // R5 address set
      send(8'((a * 37 + 11) & 255), 1'b0);
      read_word(5'(a), "R4 high nibble");
      read_word(5'((a + 1) & 31), "R9 low nibble at address+1");
    end
    check_all("R4 sweep");

    // R4 counter advances by 2: two back-to-back frames
    send(8'h1e, 1'b1);
    send(8'ha5, 1'b0);
    send(8'h3c, 1'b0);
    check_all("R9 consecutive frames across wrap");

    // R7: rewrite one nibble at each address, bit 4 set on odd addresses
    send(8'h00, 1'b1);
    for (int a = 0; a < 32; a++)
      send({3'b100, 1'(a & 1), 4'((a * 5 + 3) & 15)}, 1'b1);
    check_all("R7 nibble sweep");
    send({3'b100, 1'b0, 4'h9}, 1'b1);   // counter wrapped to 0
    read_word(5'd0, "R9 nibble after wrap");

    // R6 modes leave memory
    send(8'h20, 1'b1); check_all("R6 all on");
    send(8'h60, 1'b1); check_all("R6 show memory");
    send(8'h40, 1'b1); check_all("R6 all off");
    send(8'h7f, 1'b1); check_all("R6 show with junk bits");

    // R10 unused opcodes, then probe counter with a nibble write
    send(8'h0a, 1'b1);
    send(8'hbf, 1'b1);
    send(8'hff, 1'b1);
    check_all("R10 unused opcodes");
    send(8'h86, 1'b1);
    read_word(5'd10, "R10 counter untouched");
    read_word(5'd11, "R10 neighbour untouched");

    // R2: sck edges with cs high do nothing
    cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sd = 1'b1; cd = 1'b0;
      clks(HALF_SCK); sck = 1'b1; clks(HALF_SCK); sck = 1'b0;
    end
    clks(6);
    check_all("R2 edges with cs high");
    send(8'h8c, 1'b1);
    read_word(5'd11, "R2 counter unchanged");

    // R3 partial frames discarded, then a clean frame starts at bit 7
    send(8'h00, 1'b1);
    send(8'hff, 1'b0, 5);
    send(8'hff, 1'b1, 7);
    check_all("R3 partial dropped");
    send(8'h5a, 1'b0);
    read_word(5'd0, "R3 restart high");
    read_word(5'd1, "R3 restart low");
    read_word(5'd2, "R3 counter +2");

    // R8 clear command keeps memory
    send(8'h14, 1'b1);
    send(8'h20, 1'b1);
    send(8'hc0, 1'b1);
    check_all("R8 clear");
    send(8'h83, 1'b1);
    read_word(5'd0, "R8 counter at 0");
    read_word(5'd20, "R8 memory kept");

    // R11 cd level before the 8th edge: covered by every send; a data frame with
    // cd high on bits 7..1 must still be data
    send(8'h10, 1'b1);
    send(8'h21, 1'b0);
    check("R11 data despite early cd", int'(disp_mode), int'(mode_m));
    read_word(5'd16, "R11 high");
    read_word(5'd17, "R11 low");

    // R1 asynchronous reset mid-run
    send(8'h20, 1'b1);
    clks(1);
    #1 rst_n = 1'b0;
    clks(2);
    model_reset();
    check("R1 async reset mode", int'(disp_mode), 0);
    rst_n = 1'b1;
    clks(3);
    check_all("R1 after async reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule